// File: doc/BRIEF.md
# Infrared SIR Pulse Modem

This block sits between a UART's serial bit stream and an infrared transceiver. On the transmit side, every zero bit becomes one short active pulse at the start of its bit cell, and every one bit leaves the line idle. Two pulse lengths are available: a fixed width timed on the reference clock, or three sixteenths of a bit time counted on the 16x oversample tick. On the receive side, each rising edge of the incoming pulse (after optional inversion) is turned back into a zero bit that lasts one bit time. A raw copy of the UART bit passes out on a bypass pin so that a wired transceiver can be used while the infrared path is off.

A two-bit mode selector enables the function. Its upper bit clear turns the function off. Code 10 chooses the fixed-time pulse and code 11 chooses the 3/16 pulse. Separate controls invert the transmit pin and the receive pin. A duplex control picks full duplex (used for loopback self-test) or half duplex. In half duplex, two optional guard windows, each four characters of ten bits long, protect the change of direction. One window blanks the receiver after transmission ends. The other holds off the UART, by dropping a ready line, after the most recent pulse was received.

The UART drives `txBitStrobe` for one clock at the start of each bit cell, in a cycle where `tick16` is also high. It holds `txActive` high while a character is in flight.

Top module: `irSirModem`

## Requirements
- R1: Out of reset every control is zero, so the modem is off: `irTxPin` is 0, `rxBit` is 1 and `txReady` is 1.
- R2: With mode code 11, a strobe with `txBit`=0 makes the pulse go active on that same clock edge. The pulse stays active for exactly 3 oversample ticks, and only one pulse is produced per bit.
- R3: With mode code 10, a zero bit produces one pulse of ceil(CLK_KHZ*PULSE_NS/1e6) clock cycles, which is 80 cycles at the defaults.
- R4: A strobe with `txBit`=1 produces no pulse: the pin stays at its idle level for the whole bit.
- R5: With `txInv`=1 the transmit pin idles at 1 and the pulse is driven low. Its width is unchanged.
- R6: With mode codes 00 or 01, `irTxPin` stays equal to `txInv`, received pulses leave `rxBit` at 1, and `bypassTx` always equals `txBit`.
- R7: A rising edge of the active received level drives `rxBit` to 0 within 3 clocks. `rxBit` stays 0 for OVERSAMPLE ticks and then returns to 1.
- R8: With `rxInv`=1 the receive pin idles at 1, and a low-going pulse is decoded like a high-going pulse is when `rxInv`=0.
- R9: In half duplex (`halfDuplex`=1), `rxBit` is held at 1 while `txActive` is high. In full duplex, pulses are decoded while transmitting.
- R10: In half duplex with `rxDelayEn`=1, received pulses are ignored for 4 characters × 10 bits × 16 ticks after `txActive` falls. With `rxDelayEn`=0 they are decoded at once.
- R11: In half duplex with `txDelayEn`=1, every decoded pulse drops `txReady` for 640 ticks, and zero-bit strobes during that window produce no pulse. With `txDelayEn`=0, `txReady` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-clock enable at 16x the bit rate |
| modeSel | input | 2 | 0x off, 10 fixed-time pulse, 11 3/16 pulse |
| txInv | input | 1 | Invert the infrared transmit pin |
| rxInv | input | 1 | Invert the infrared receive pin |
| halfDuplex | input | 1 | 1 half duplex, 0 full duplex |
| rxDelayEn | input | 1 | Enable the receive guard after transmitting |
| txDelayEn | input | 1 | Enable the transmit guard after receiving |
| txBit | input | 1 | Serial bit from the UART |
| txBitStrobe | input | 1 | Start of a bit cell, coincident with a tick |
| txActive | input | 1 | UART is sending a character |
| txReady | output | 1 | UART may start a character |
| bypassTx | output | 1 | Raw copy of `txBit` |
| irTxPin | output | 1 | Infrared transmit pin |
| irRxPin | input | 1 | Infrared receive pin |
| rxBit | output | 1 | Decoded serial bit to the UART |

## Verification
The bench keeps the default parameters: a 50 MHz reference with a 1600 ns pulse, giving an 80-cycle fixed pulse, and 16x oversampling with four ten-bit guard characters, giving 640 ticks. It drives one tick every ten clocks, so a bit lasts 160 clocks, the 3/16 pulse lasts 30 clocks, and each guard window lasts about 6400 clocks. At these values both pulse widths can be told apart and measured cycle by cycle. Each guard window can be probed near its end as well as after it, and the run stays well within the cycle budget.

// File: rtl/irSirPkg.sv
package irSirPkg;
  typedef enum logic [1:0] {
    MODE_OFF_A = 2'b00,
    MODE_OFF_B = 2'b01,
    MODE_FIXED = 2'b10,
    MODE_TICK  = 2'b11
  } irMode_e;

  typedef struct packed {
    logic enabled;
    logic fixedMode;
    logic txAllow;
    logic rxBlock;
  } sirStrobe_t;
endpackage

// File: rtl/irSirCtrl.sv
module irSirCtrl
  import irSirPkg::*;
#(
  parameter int OVERSAMPLE    = 16,
  parameter int BITS_PER_CHAR = 10,
  parameter int GUARD_CHARS   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic [1:0] modeSel,
  input  logic       halfDuplex,
  input  logic       rxDelayEn,
  input  logic       txDelayEn,
  input  logic       txActive,
  input  logic       rxPulseSeen,
  output sirStrobe_t strobes,
  output logic       txReady
);
  localparam int GUARD_TICKS = OVERSAMPLE * BITS_PER_CHAR * GUARD_CHARS;
  localparam int GW = $clog2(GUARD_TICKS + 1);

  logic          enabled;
  logic          guardOn;
  logic          txActD;
  logic [GW-1:0] rxGuardCnt;
  logic [GW-1:0] txGuardCnt;

  assign enabled = (modeSel == MODE_FIXED) || (modeSel == MODE_TICK);
  assign guardOn = enabled & halfDuplex;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txActD     <= 1'b0;
      rxGuardCnt <= '0;
      txGuardCnt <= '0;
    end else begin
      txActD <= txActive;
      if (!guardOn)
        rxGuardCnt <= '0;
      else if (rxDelayEn && txActD && !txActive)
        rxGuardCnt <= GW'(GUARD_TICKS);
      else if (tick16 && rxGuardCnt != '0)
        rxGuardCnt <= rxGuardCnt - 1'b1;

      if (!guardOn)
        txGuardCnt <= '0;
      else if (txDelayEn && rxPulseSeen)
        txGuardCnt <= GW'(GUARD_TICKS);
      else if (tick16 && txGuardCnt != '0)
        txGuardCnt <= txGuardCnt - 1'b1;
    end
  end

  assign txReady           = (txGuardCnt == '0);
  assign strobes.enabled   = enabled;
  assign strobes.fixedMode = (modeSel == MODE_FIXED);
  assign strobes.txAllow   = txReady;
  assign strobes.rxBlock   = guardOn & (txActive | (rxGuardCnt != '0));

  // R10: the end of a transmission opens the receive guard
  a_r10_rx_guard_opens: assert property (@(posedge clk) disable iff (!rstN)
    (guardOn && rxDelayEn && $fell(txActive)) |=> strobes.rxBlock);

  // R11: a decoded pulse drops ready when the transmit guard is enabled
  a_r11_ready_drops: assert property (@(posedge clk) disable iff (!rstN)
    (guardOn && txDelayEn && rxPulseSeen) |=> !txReady);

  // R9: half duplex blanks reception while transmitting
  a_r9_blank_tx: assert property (@(posedge clk) disable iff (!rstN)
    (guardOn && txActive) |-> strobes.rxBlock);
endmodule

// File: rtl/irSirDatapath.sv
module irSirDatapath
  import irSirPkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int FIXED_CYC  = 80
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  sirStrobe_t strobes,
  input  logic       txBit,
  input  logic       txBitStrobe,
  input  logic       txInv,
  input  logic       rxInv,
  input  logic       irRxPin,
  output logic       irTxPin,
  output logic       rxBit,
  output logic       rxPulseSeen
);
  localparam int TICK_PULSE = (3 * OVERSAMPLE) / 16;
  localparam int PMAX = (FIXED_CYC > TICK_PULSE) ? FIXED_CYC : TICK_PULSE;
  localparam int PW = $clog2(PMAX + 1);
  localparam int HW = $clog2(OVERSAMPLE + 1);

  logic          pulseOn;
  logic [PW-1:0] pulseCnt;
  logic          pulseStart;
  logic          sync1, sync2, prevLvl;
  logic          rxEdge;
  logic [HW-1:0] holdCnt;

  // transmit encoder
  assign pulseStart = txBitStrobe & ~txBit & strobes.enabled & strobes.txAllow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseOn  <= 1'b0;
      pulseCnt <= '0;
    end else if (!strobes.enabled) begin
      pulseOn  <= 1'b0;
      pulseCnt <= '0;
    end else if (pulseStart) begin
      pulseOn  <= 1'b1;
      pulseCnt <= '0;
    end else if (pulseOn) begin
      if (strobes.fixedMode) begin
        if (pulseCnt == PW'(FIXED_CYC - 1)) pulseOn <= 1'b0;
        else pulseCnt <= pulseCnt + 1'b1;
      end else if (tick16) begin
        if (pulseCnt == PW'(TICK_PULSE - 1)) pulseOn <= 1'b0;
        else pulseCnt <= pulseCnt + 1'b1;
      end
    end
  end

  assign irTxPin = (pulseOn & strobes.enabled) ^ txInv;

  // receive decoder
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1   <= 1'b0;
      sync2   <= 1'b0;
      prevLvl <= 1'b0;
    end else begin
      sync1   <= irRxPin ^ rxInv;
      sync2   <= sync1;
      prevLvl <= sync2;
    end
  end

  assign rxEdge      = sync2 & ~prevLvl;
  assign rxPulseSeen = rxEdge & strobes.enabled & ~strobes.rxBlock;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      holdCnt <= '0;
    else if (!strobes.enabled || strobes.rxBlock)
      holdCnt <= '0;
    else if (rxEdge)
      holdCnt <= HW'(OVERSAMPLE);
    else if (tick16 && holdCnt != '0)
      holdCnt <= holdCnt - 1'b1;
  end

  assign rxBit = (holdCnt == '0);

  // R2: a zero bit starts its pulse on the strobe edge
  a_r2_zero_starts: assert property (@(posedge clk) disable iff (!rstN)
    pulseStart |=> pulseOn);

  // R4: a one bit never starts a pulse
  a_r4_one_no_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (txBitStrobe && txBit && !pulseOn) |=> !pulseOn);

  // R3: the width counter stays inside the fixed-pulse window
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt < PW'(PMAX));

  // R11: no pulse starts while the UART is stalled
  a_r11_stall_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.txAllow && !pulseOn) |=> !pulseOn);

  // R9: a blanked receiver reports idle
  a_r9_block_idle: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rxBlock |=> rxBit);

  // R7: an accepted edge becomes a zero bit
  a_r7_edge_zero: assert property (@(posedge clk) disable iff (!rstN)
    rxPulseSeen |=> !rxBit);
endmodule

// File: rtl/irSirModem.sv
module irSirModem
  import irSirPkg::*;
#(
  parameter int CLK_KHZ       = 50000,
  parameter int PULSE_NS      = 1600,
  parameter int OVERSAMPLE    = 16,
  parameter int BITS_PER_CHAR = 10,
  parameter int GUARD_CHARS   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic [1:0] modeSel,
  input  logic       txInv,
  input  logic       rxInv,
  input  logic       halfDuplex,
  input  logic       rxDelayEn,
  input  logic       txDelayEn,
  input  logic       txBit,
  input  logic       txBitStrobe,
  input  logic       txActive,
  output logic       txReady,
  output logic       bypassTx,
  output logic       irTxPin,
  input  logic       irRxPin,
  output logic       rxBit
);
  localparam int FIXED_CYC = (CLK_KHZ * PULSE_NS + 999999) / 1000000;

  sirStrobe_t strobes;
  logic       rxPulseSeen;

  assign bypassTx = txBit;

  irSirCtrl #(
    .OVERSAMPLE(OVERSAMPLE),
    .BITS_PER_CHAR(BITS_PER_CHAR),
    .GUARD_CHARS(GUARD_CHARS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tick16(tick16), .modeSel(modeSel),
    .halfDuplex(halfDuplex), .rxDelayEn(rxDelayEn), .txDelayEn(txDelayEn),
    .txActive(txActive), .rxPulseSeen(rxPulseSeen),
    .strobes(strobes), .txReady(txReady)
  );

  irSirDatapath #(
    .OVERSAMPLE(OVERSAMPLE),
    .FIXED_CYC(FIXED_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tick16(tick16), .strobes(strobes),
    .txBit(txBit), .txBitStrobe(txBitStrobe), .txInv(txInv), .rxInv(rxInv),
    .irRxPin(irRxPin), .irTxPin(irTxPin), .rxBit(rxBit),
    .rxPulseSeen(rxPulseSeen)
  );
endmodule

// File: tb/irSirModem_tb.sv
`timescale 1ns/1ps
module irSirModem_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       txInv = 1'b0, rxInv = 1'b0, halfDuplex = 1'b0;
  logic       rxDelayEn = 1'b0, txDelayEn = 1'b0;
  logic       txBit = 1'b1, txBitStrobe = 1'b0, txActive = 1'b0;
  logic       irRxPin = 1'b0;
  logic       txReady, bypassTx, irTxPin, rxBit;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int tickCnt = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    tickCnt <= (tickCnt == 9) ? 0 : tickCnt + 1;
    tick16 <= (tickCnt == 9);
  end

  irSirModem u_dut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .modeSel(modeSel),
    .txInv(txInv), .rxInv(rxInv), .halfDuplex(halfDuplex),
    .rxDelayEn(rxDelayEn), .txDelayEn(txDelayEn), .txBit(txBit),
    .txBitStrobe(txBitStrobe), .txActive(txActive), .txReady(txReady),
    .bypassTx(bypassTx), .irTxPin(irTxPin), .irRxPin(irRxPin), .rxBit(rxBit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // strobe one bit cell and measure the active pulse width in clocks
  task automatic sendBit(input logic b, output int w);
    while (tick16 !== 1'b1) waitClk(1);
    txBit = b;
    txBitStrobe = 1'b1;
    waitClk(1);
    txBitStrobe = 1'b0;
    w = 0;
    while (((irTxPin ^ txInv) == 1'b1) && w < 300) begin
      waitClk(1);
      w++;
    end
  endtask

  task automatic pinActive();
    irRxPin = ~rxInv;
  endtask

  task automatic pinIdle();
    irRxPin = rxInv;
  endtask

  // pulse the receive pin, check rxBit at +5, then let the hold expire
  task automatic rxProbe(input logic expZero, input string req);
    pinActive();
    waitClk(5);
    check(rxBit == !expZero, req, rxBit, !expZero);
    waitClk(25);
    pinIdle();
    waitClk(200);
  endtask

  task automatic tReset();
    check(irTxPin == 1'b0, "R1 txpin", irTxPin, 0);
    check(rxBit == 1'b1, "R1 rxbit", rxBit, 1);
    check(txReady == 1'b1, "R1 ready", txReady, 1);
    txBit = 1'b0; #1;
    check(bypassTx == 1'b0, "R6 bypass0", bypassTx, 0);
    txBit = 1'b1; #1;
    check(bypassTx == 1'b1, "R6 bypass1", bypassTx, 1);
  endtask

  task automatic tTickMode();
    int w;
    modeSel = 2'b11;
    waitClk(2);
    sendBit(1'b0, w);
    check(w == 30, "R2 tick pulse width", w, 30);
    waitClk(200);
    check(irTxPin == 1'b0, "R2 single pulse", irTxPin, 0);
    sendBit(1'b1, w);
    check(w == 0, "R4 one bit no pulse", w, 0);
    waitClk(150);
    check(irTxPin == 1'b0, "R4 idle after one", irTxPin, 0);
  endtask

  task automatic tFixed();
    int w;
    modeSel = 2'b10;
    waitClk(2);
    sendBit(1'b0, w);
    check(w == 80, "R3 fixed pulse width", w, 80);
    waitClk(100);
  endtask

  task automatic tInvert();
    int w;
    modeSel = 2'b11;
    txInv = 1'b1;
    waitClk(2);
    check(irTxPin == 1'b1, "R5 inverted idle", irTxPin, 1);
    sendBit(1'b0, w);
    check(w == 30, "R5 inverted width", w, 30);
    txInv = 1'b0;
    waitClk(150);
  endtask

  task automatic tDisabled();
    int w;
    for (int m = 0; m < 2; m++) begin
      modeSel = 2'(m);
      txInv = m[0];
      waitClk(2);
      sendBit(1'b0, w);
      check(w == 0, "R6 off no pulse", w, 0);
      check(irTxPin == txInv, "R6 off idle level", irTxPin, txInv);
      check(bypassTx == 1'b0, "R6 bypass follows", bypassTx, 0);
      rxProbe(1'b0, "R6 off rx ignored");
    end
    txInv = 1'b0;
    txBit = 1'b1;
    waitClk(2);
  endtask

  task automatic tDecode();
    modeSel = 2'b11;
    waitClk(2);
    pinActive();
    waitClk(5);
    check(rxBit == 1'b0, "R7 zero decoded", rxBit, 0);
    waitClk(25);
    pinIdle();
    waitClk(110);
    check(rxBit == 1'b0, "R7 held one bit", rxBit, 0);
    waitClk(35);
    check(rxBit == 1'b1, "R7 returns to one", rxBit, 1);
  endtask

  task automatic tRxInv();
    rxInv = 1'b1;
    irRxPin = 1'b1;
    waitClk(200);
    check(rxBit == 1'b1, "R8 inverted idle", rxBit, 1);
    rxProbe(1'b1, "R8 inverted decode");
    rxInv = 1'b0;
    irRxPin = 1'b0;
    waitClk(200);
  endtask

  task automatic tDuplex();
    halfDuplex = 1'b1;
    txActive = 1'b1;
    waitClk(2);
    rxProbe(1'b0, "R9 half blanks");
    halfDuplex = 1'b0;
    waitClk(2);
    rxProbe(1'b1, "R9 full decodes");
    txActive = 1'b0;
    waitClk(20);
  endtask

  task automatic tRxGuard();
    halfDuplex = 1'b1;
    rxDelayEn = 1'b1;
    txActive = 1'b1;
    waitClk(20);
    txActive = 1'b0;
    waitClk(10);
    rxProbe(1'b0, "R10 guard start");
    waitClk(5560);
    rxProbe(1'b0, "R10 guard late");
    waitClk(700);
    rxProbe(1'b1, "R10 after guard");
    rxDelayEn = 1'b0;
    txActive = 1'b1;
    waitClk(20);
    txActive = 1'b0;
    waitClk(10);
    rxProbe(1'b1, "R10 no delay");
  endtask

  task automatic tTxGuard();
    int w;
    halfDuplex = 1'b1;
    txDelayEn = 1'b1;
    modeSel = 2'b11;
    pinActive();
    waitClk(5);
    check(txReady == 1'b0, "R11 ready drops", txReady, 0);
    waitClk(25);
    pinIdle();
    waitClk(270);
    sendBit(1'b0, w);
    check(w == 0, "R11 stalled no pulse", w, 0);
    waitClk(5690);
    check(txReady == 1'b0, "R11 still stalled", txReady, 0);
    waitClk(600);
    check(txReady == 1'b1, "R11 ready back", txReady, 1);
    sendBit(1'b0, w);
    check(w == 30, "R11 pulse after guard", w, 30);
    txDelayEn = 1'b0;
    waitClk(200);
    pinActive();
    waitClk(5);
    check(txReady == 1'b1, "R11 no delay ready", txReady, 1);
    waitClk(25);
    pinIdle();
    waitClk(200);
    halfDuplex = 1'b0;
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    tReset();
    tTickMode();
    tFixed();
    tInvert();
    tDisabled();
    tDecode();
    tRxInv();
    tDuplex();
    tRxGuard();
    tTxGuard();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule